// File: doc/BRIEF.md
# Flash program/erase poller

This block sits on the host side of a word-wide parallel NOR flash and turns one request into a complete write operation. A request names an operation: word program, sector erase, block erase or chip erase. It also gives a target address, a data word for programs, and a completion-detection method. The block then drives the unlock and command writes over a simple synchronous bus port, in which each transfer completes in a cycle where `bus_ready` is high. After that it reads the target location repeatedly until the device reports that the operation has finished.

There are two detection methods. In toggle mode, the operation is treated as finished when two back-to-back reads show the same value of bit 6. In data-polling mode, it is finished when bit 7 of the read word matches bit 7 of the expected final word. Any apparent completion must hold for two further reads before it is accepted. A full-word verify read follows. When the verify read disagrees, the block reads the location twice more before it reports an error, because a device may release the low bits later than the status bits.

Each operation class has its own limit on polling time, set in clock cycles. The block ends with a one-cycle `done` pulse and a result code. Requests that arrive while an operation is in flight are refused.

Top module: `flash_op_poller`

## Requirements
- R1: A word program (op code 0) is issued as exactly four bus writes, in this order: 0x0AA to address 0x555, 0x055 to 0x2AA, 0x0A0 to 0x555, then the request data to the request address. Command data words have zero upper bits.
- R2: An erase is issued as exactly six bus writes: 0x0AA to 0x555, 0x055 to 0x2AA, 0x080 to 0x555, 0x0AA to 0x555, 0x055 to 0x2AA, then a final write. The final write depends on the op code. Chip erase (op 3) writes 0x010 to 0x555. Sector erase (op 1) writes 0x050 to the request address. Block erase (op 2) writes 0x030 to the request address.
- R3: After the last command write, the block reads the request address. In toggle mode (`req_mode`=0), a candidate completion is two consecutive reads with equal bit 6.
- R4: In data-polling mode (`req_mode`=1), a candidate completion is a read whose bit 7 equals bit 7 of the expected word. The expected word is the request data for a program and all ones for any erase.
- R5: A candidate completion is accepted only if the next two reads also meet the condition. If either fails, polling continues.
- R6: After acceptance, one verify read of the whole word is compared with the expected word. A match ends the operation with result 0 (success), and `final_word` carries the word read.
- R7: On a verify mismatch, two further reads are made. If both match, the result is 0. If either mismatches, the operation ends at once with result 1 (error).
- R8: If no completion is accepted after polling has run for a limit number of cycles, the operation ends with result 2 (timeout). There are separate limits for program, sector/block erase and chip erase.
- R9: A request made while `busy` is high is dropped, `refused` pulses in the next cycle, and the running operation continues unchanged.
- R10: `done` is a one-cycle pulse that carries `result`. `busy` is low from that cycle on, and no bus read or write is issued while `busy` is low.
- R11: During reset, `busy`, `done`, `refused`, `bus_wr` and `bus_rd` are all low.
- R12: While a bus transfer is pending and `bus_ready` is low, `bus_wr`, `bus_rd`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_mode | input | 1 | 0 toggle-bit detection, 1 data-polling detection |
| req_addr | input | ADDR_W | Target word, sector or block address |
| req_data | input | DATA_W | Word to program |
| busy | output | 1 | Operation in flight |
| refused | output | 1 | Pulse: a request arrived while busy |
| done | output | 1 | Pulse: operation finished |
| result | output | 2 | 0 success, 1 error, 2 timeout; valid with done |
| final_word | output | DATA_W | Last verify word read |
| bus_wr | output | 1 | Bus write request |
| bus_rd | output | 1 | Bus read request |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid when a read completes |
| bus_ready | input | 1 | Transfer completes in this cycle |

## Verification
The bench builds the block with a 22-bit address, a 16-bit word and cycle limits of 40, 60 and 80 for program, sector/block erase and chip erase. These short limits let a device model that never finishes reach the timeout within a few dozen cycles. They also make the choice between the three limits visible in the measured latency. The model can present a stretched ready pattern, a spurious early status match and a chosen number of late-settling reads. This puts the confirmation path, the recheck that rescues a slow verify and the recheck that reports an error all within reach.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SECTOR = 2'd1,
        OP_BLOCK  = 2'd2,
        OP_CHIP   = 2'd3
    } flash_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_ERROR   = 2'd1,
        RES_TIMEOUT = 2'd2
    } flash_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_CONFIRM,
        ST_VERIFY,
        ST_RECHECK
    } poll_state_e;

    // unlock addresses (low address bits only)
    localparam logic [10:0] UNLOCK_HI = 11'h555;
    localparam logic [10:0] UNLOCK_LO = 11'h2AA;

    // command codes
    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_WRITE  = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECTOR = 8'h50;
    localparam logic [7:0] CODE_BLOCK  = 8'h30;

    // status bit positions in the read word
    localparam int TOG_BIT   = 6;
    localparam int DPOLL_BIT = 7;

    localparam int PROG_STEPS  = 4;
    localparam int ERASE_STEPS = 6;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  flash_op_e           op,
    input  logic [2:0]          step,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [DATA_W-1:0]   tgt_data,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0]   cmd_data,
    output logic                cmd_last
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_LO);

    logic [7:0] final_code;

    always_comb begin
        case (op)
            OP_CHIP:   final_code = CODE_CHIP;
            OP_SECTOR: final_code = CODE_SECTOR;
            default:   final_code = CODE_BLOCK;
        endcase
    end

    always_comb begin
        cmd_addr = A_HI;
        cmd_data = DATA_W'(CODE_KEY1);
        cmd_last = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0: begin cmd_addr = A_HI; cmd_data = DATA_W'(CODE_KEY1); end
                3'd1: begin cmd_addr = A_LO; cmd_data = DATA_W'(CODE_KEY2); end
                3'd2: begin cmd_addr = A_HI; cmd_data = DATA_W'(CODE_WRITE); end
                default: begin
                    cmd_addr = tgt_addr;
                    cmd_data = tgt_data;
                    cmd_last = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin cmd_addr = A_HI; cmd_data = DATA_W'(CODE_KEY1); end
                3'd1: begin cmd_addr = A_LO; cmd_data = DATA_W'(CODE_KEY2); end
                3'd2: begin cmd_addr = A_HI; cmd_data = DATA_W'(CODE_ERASE); end
                3'd3: begin cmd_addr = A_HI; cmd_data = DATA_W'(CODE_KEY1); end
                3'd4: begin cmd_addr = A_LO; cmd_data = DATA_W'(CODE_KEY2); end
                default: begin
                    cmd_addr = (op == OP_CHIP) ? A_HI : tgt_addr;
                    cmd_data = DATA_W'(final_code);
                    cmd_last = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge (
    input  logic mode_dpoll,
    input  logic prev_vld,
    input  logic prev_tog,
    input  logic rd_tog,
    input  logic rd_dpoll,
    input  logic exp_dpoll,
    output logic hit
);
    always_comb begin
        if (mode_dpoll) hit = (rd_dpoll == exp_dpoll);
        else            hit = prev_vld && (rd_tog == prev_tog);
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (en && cnt_q < limit) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/flash_op_poller.sv
module flash_op_poller
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int PROG_LIMIT  = 500,
    parameter int ERASE_LIMIT = 1250000,
    parameter int CHIP_LIMIT  = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              refused,
    output logic              done,
    output logic [1:0]        result,
    output logic [DATA_W-1:0] final_word,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    localparam int MAX_A   = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
    localparam int MAX_LIM = (MAX_A > CHIP_LIMIT) ? MAX_A : CHIP_LIMIT;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    typedef struct packed {
        poll_state_e       state;
        logic [2:0]        step;
        logic              k;
        logic              prev_tog;
        logic              prev_vld;
        flash_op_e         op;
        logic              mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              done;
        logic [1:0]        result;
        logic              refused;
        logic [DATA_W-1:0] word;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;
    logic [DATA_W-1:0] exp_word;
    logic              hit;
    logic              expired;
    logic              tmr_clr, tmr_en;
    logic [CNT_W-1:0]  limit;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .op       (r_q.op),
        .step     (r_q.step),
        .tgt_addr (r_q.addr),
        .tgt_data (r_q.data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .cmd_last (cmd_last)
    );

    assign exp_word = (r_q.op == OP_PROG) ? r_q.data : {DATA_W{1'b1}};

    flash_poll_judge u_judge (
        .mode_dpoll (r_q.mode),
        .prev_vld   (r_q.prev_vld),
        .prev_tog   (r_q.prev_tog),
        .rd_tog     (bus_rdata[TOG_BIT]),
        .rd_dpoll   (bus_rdata[DPOLL_BIT]),
        .exp_dpoll  (exp_word[DPOLL_BIT]),
        .hit        (hit)
    );

    always_comb begin
        case (r_q.op)
            OP_PROG: limit = CNT_W'(PROG_LIMIT);
            OP_CHIP: limit = CNT_W'(CHIP_LIMIT);
            default: limit = CNT_W'(ERASE_LIMIT);
        endcase
    end

    assign tmr_clr = (r_q.state == ST_CMD) && bus_ready && cmd_last;
    assign tmr_en  = (r_q.state == ST_POLL) || (r_q.state == ST_CONFIRM);

    flash_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (limit),
        .expired (expired)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.refused = req_valid && (r_q.state != ST_IDLE);
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op    = flash_op_e'(req_op);
                    r_d.mode  = req_mode;
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.step  = '0;
                    r_d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                if (bus_ready) begin
                    if (cmd_last) begin
                        r_d.state    = ST_POLL;
                        r_d.prev_vld = 1'b0;
                    end else begin
                        r_d.step = r_q.step + 3'd1;
                    end
                end
            end
            ST_POLL: begin
                if (bus_ready) begin
                    r_d.prev_tog = bus_rdata[TOG_BIT];
                    r_d.prev_vld = 1'b1;
                    if (hit) begin
                        r_d.state = ST_CONFIRM;
                        r_d.k     = 1'b0;
                    end else if (expired) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_TIMEOUT;
                    end
                end
            end
            ST_CONFIRM: begin
                if (bus_ready) begin
                    r_d.prev_tog = bus_rdata[TOG_BIT];
                    if (hit) begin
                        if (r_q.k) r_d.state = ST_VERIFY;
                        else       r_d.k     = 1'b1;
                    end else if (expired) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_TIMEOUT;
                    end else begin
                        r_d.state = ST_POLL;
                    end
                end
            end
            ST_VERIFY: begin
                if (bus_ready) begin
                    r_d.word = bus_rdata;
                    if (bus_rdata == exp_word) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_OK;
                    end else begin
                        r_d.state = ST_RECHECK;
                        r_d.k     = 1'b0;
                    end
                end
            end
            ST_RECHECK: begin
                if (bus_ready) begin
                    r_d.word = bus_rdata;
                    if (bus_rdata != exp_word) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_ERROR;
                    end else if (r_q.k) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_OK;
                    end else begin
                        r_d.k = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign refused    = r_q.refused;
    assign done       = r_q.done;
    assign result     = r_q.result;
    assign final_word = r_q.word;
    assign bus_wr     = (r_q.state == ST_CMD);
    assign bus_rd     = busy && (r_q.state != ST_CMD);
    assign bus_addr   = bus_wr ? cmd_addr : r_q.addr;
    assign bus_wdata  = bus_wr ? cmd_data : '0;
endmodule

// File: rtl/flash_op_poller_chk.sv
module flash_op_poller_chk #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              refused,
    input logic              done,
    input logic [1:0]        result,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready
);
    p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_ready) |=>
            ($stable(bus_wr) && $stable(bus_rd) && $stable(bus_addr) && $stable(bus_wdata)));

    p_one_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_wr && !bus_rd));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_end_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_result_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));

    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> refused);
endmodule

bind flash_op_poller flash_op_poller_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_op_poller_bench.sv
module flash_op_poller_bench;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int PROG_TO  = 40;
    localparam int ERASE_TO = 60;
    localparam int CHIP_TO  = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic          req_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, refused, done;
    logic [1:0]    result;
    logic [DW-1:0] final_word;
    logic          bus_wr, bus_rd, bus_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    flash_op_poller #(.ADDR_W(AW), .DATA_W(DW), .PROG_LIMIT(PROG_TO),
                      .ERASE_LIMIT(ERASE_TO), .CHIP_LIMIT(CHIP_TO)) u_flash_op_poller (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .refused(refused), .done(done), .result(result),
        .final_word(final_word), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    // ---------------- device model ----------------
    logic [1:0]  m_op = '0;
    logic [15:0] m_data = '0;
    int          m_busy = 0;
    int          m_late = 0;
    logic        m_glitch = 1'b0, m_never = 1'b0, m_slow = 1'b0, m_clr = 1'b0;
    int          cyc = 0;
    int          rd_cnt = 0;
    logic [3:0]  wr_cnt = '0;
    logic [AW-1:0] log_a [8];
    logic [DW-1:0] log_d [8];

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (m_clr) begin
            wr_cnt <= '0;
            rd_cnt <= 0;
        end else begin
            if (bus_wr && bus_ready) begin
                if (wr_cnt < 4'd8) begin
                    log_a[wr_cnt[2:0]] <= bus_addr;
                    log_d[wr_cnt[2:0]] <= bus_wdata;
                end
                wr_cnt <= wr_cnt + 4'd1;
                rd_cnt <= 0;
            end
            if (bus_rd && bus_ready) rd_cnt <= rd_cnt + 1;
        end
    end

    assign bus_ready = m_slow ? cyc[0] : 1'b1;

    logic [15:0] m_exp;
    always_comb begin
        m_exp = (m_op == 2'd0) ? m_data : 16'hFFFF;
        if (m_never || rd_cnt < m_busy) begin
            bus_rdata = {m_exp[15:8], (m_op == 2'd0) ? ~m_exp[7] : 1'b0, rd_cnt[0], m_exp[5:0]};
            if (m_glitch && rd_cnt == 1) bus_rdata[7] = m_exp[7];
        end else if (rd_cnt - m_busy < m_late) begin
            bus_rdata = m_exp ^ 16'h0F00;
        end else begin
            bus_rdata = m_exp;
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [37:0] exp_wr(input logic [1:0] op, input int i,
                                           input logic [21:0] a, input logic [15:0] d);
        if (op == 2'd0) begin
            case (i)
                0: return {22'h555, 16'h00AA};
                1: return {22'h2AA, 16'h0055};
                2: return {22'h555, 16'h00A0};
                default: return {a, d};
            endcase
        end
        case (i)
            0, 3: return {22'h555, 16'h00AA};
            1, 4: return {22'h2AA, 16'h0055};
            2: return {22'h555, 16'h0080};
            default: begin
                if (op == 2'd3) return {22'h555, 16'h0010};
                if (op == 2'd1) return {a, 16'h0050};
                return {a, 16'h0030};
            end
        endcase
    endfunction

    task automatic check_log(input logic [1:0] op, input logic [21:0] a, input logic [15:0] d);
        int n = (op == 2'd0) ? 4 : 6;
        logic ok = (int'(wr_cnt) == n);
        logic [37:0] bad_act = '0, bad_exp = '0;
        for (int i = 0; i < n; i++) begin
            if ({log_a[i], log_d[i]} != exp_wr(op, i, a, d)) begin
                ok = 1'b0;
                bad_act = {log_a[i], log_d[i]};
                bad_exp = exp_wr(op, i, a, d);
            end
        end
        if (ok) check(1'b1, "R1/R2 command writes", 0, 0);
        else if (op == 2'd0) check(1'b0, "R1 program writes", {26'd0, wr_cnt, bad_act}, {26'd0, 4'(n), bad_exp});
        else check(1'b0, "R2 erase writes", {26'd0, wr_cnt, bad_act}, {26'd0, 4'(n), bad_exp});
    endtask

    task automatic cfg(input logic [1:0] op, input logic [15:0] d, input int nb, input int nl,
                       input logic gl, input logic nv, input logic sl);
        @(negedge clk);
        m_op = op; m_data = d; m_busy = nb; m_late = nl;
        m_glitch = gl; m_never = nv; m_slow = sl; m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic mode, input logic [21:0] a,
                          input logic [15:0] d, output logic [1:0] res,
                          output logic [15:0] w, output int el);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mode = mode; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        el = 1;
        while (!done && el < 3000) begin
            @(negedge clk);
            el++;
        end
        if (!done) check(1'b0, "watchdog R10 done never seen", 0, 1);
        res = result;
        w = final_word;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        mode;
        logic [21:0] addr;
        logic [15:0] data;
        logic [7:0]  nb;
        logic [3:0]  nl;
        logic        glitch;
        logic        slow;
        logic [1:0]  res;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 22'h001234, 16'hBEEF, 8'd5, 4'd0, 1'b0, 1'b0, 2'd0}, // R3 program toggle
        '{2'd0, 1'b1, 22'h3FFF00, 16'h1357, 8'd7, 4'd0, 1'b0, 1'b1, 2'd0}, // R4 program data-poll slow
        '{2'd1, 1'b1, 22'h000800, 16'h0000, 8'd6, 4'd0, 1'b0, 1'b0, 2'd0}, // R4 sector erase
        '{2'd2, 1'b0, 22'h3F8000, 16'h0000, 8'd9, 4'd0, 1'b0, 1'b1, 2'd0}, // R3 block erase toggle
        '{2'd3, 1'b1, 22'h000000, 16'h0000, 8'd4, 4'd0, 1'b0, 1'b0, 2'd0}, // R6 chip erase
        '{2'd0, 1'b1, 22'h0A0A0A, 16'hC3A5, 8'd3, 4'd4, 1'b0, 1'b0, 2'd0}, // R7 recheck rescues
        '{2'd0, 1'b1, 22'h0A0A0B, 16'hC3A5, 8'd3, 4'd5, 1'b0, 1'b0, 2'd1}, // R7 recheck error
        '{2'd1, 1'b0, 22'h004000, 16'h0000, 8'd5, 4'd10, 1'b0, 1'b0, 2'd1},// R7 erase error
        '{2'd0, 1'b1, 22'h000777, 16'h00F0, 8'd8, 4'd0, 1'b1, 1'b0, 2'd0}  // R5 spurious match
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [1:0]  res;
        logic [15:0] w;
        int          el;

        // R11 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !refused && !bus_wr && !bus_rd, "R11 reset outputs",
              {busy, done, refused, bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !bus_wr && !bus_rd, "R10 idle bus after reset", {busy, bus_wr, bus_rd}, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cfg(VECS[i].op, VECS[i].data, int'(VECS[i].nb), int'(VECS[i].nl),
                VECS[i].glitch, 1'b0, VECS[i].slow);
            run_op(VECS[i].op, VECS[i].mode, VECS[i].addr, VECS[i].data, res, w, el);
            check_log(VECS[i].op, VECS[i].addr, VECS[i].data);
            check(res == VECS[i].res, "R5/R6/R7 result", res, VECS[i].res);
            if (VECS[i].res == 2'd0)
                check(w == ((VECS[i].op == 2'd0) ? VECS[i].data : 16'hFFFF), "R6 final word",
                      w, (VECS[i].op == 2'd0) ? VECS[i].data : 16'hFFFF);
            @(negedge clk);
            check(!busy && !done, "R10 done is one cycle", {busy, done}, 0);
        end

        // R9 request while busy is refused
        cfg(2'd0, 16'h5A5A, 30, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_mode = 1'b1; req_addr = 22'h012345; req_data = 16'h5A5A;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 22'h000111; req_data = 16'h0000;
        @(negedge clk);
        req_valid = 1'b0;
        check(refused == 1'b1, "R9 refused pulse", refused, 1);
        el = 0;
        while (!done && el < 3000) begin
            @(negedge clk);
            el++;
        end
        check(result == 2'd0, "R9 running op unaffected", result, 0);
        check_log(2'd0, 22'h012345, 16'h5A5A);
        @(negedge clk);
        check(!busy && !refused, "R9 dropped request not started", {busy, refused}, 0);

        // R8 chip erase timeout, toggle mode
        cfg(2'd3, 16'h0000, 0, 0, 1'b0, 1'b1, 1'b0);
        run_op(2'd3, 1'b0, 22'h000000, 16'h0000, res, w, el);
        check(res == 2'd2, "R8 chip timeout result", res, 2);
        check(el >= CHIP_TO && el <= CHIP_TO + 12, "R8 chip timeout latency", el, CHIP_TO);

        // R8 program timeout, data-poll mode
        cfg(2'd0, 16'h0080, 0, 0, 1'b0, 1'b1, 1'b0);
        run_op(2'd0, 1'b1, 22'h000321, 16'h0080, res, w, el);
        check(res == 2'd2, "R8 program timeout result", res, 2);
        check(el >= PROG_TO && el <= PROG_TO + 12, "R8 program timeout latency", el, PROG_TO);

        // R8 block erase timeout uses erase limit
        cfg(2'd2, 16'h0000, 0, 0, 1'b0, 1'b1, 1'b0);
        run_op(2'd2, 1'b1, 22'h010000, 16'h0000, res, w, el);
        check(res == 2'd2, "R8 block timeout result", res, 2);
        check(el >= ERASE_TO && el <= ERASE_TO + 12, "R8 block timeout latency", el, ERASE_TO);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule